// File: doc/BRIEF.md
# I2C serial EEPROM slave front end

This block is the bus side of a small byte-addressed serial memory. It watches the open-drain SCL and SDA lines of an I2C bus and detects start and stop conditions. After a start it checks the control byte, which carries a fixed device code, three chip-select bits and a direction bit. When the control byte addresses this device, the block sends an acknowledge. It then either loads a two-byte word address and stores a data byte, or returns bytes from its internal address pointer. SCL is input only, because the block never stretches the clock. SDA is modelled as an input plus an output enable: when `sda_oe` is high, the pad pulls the line low.

The word address is 13 bits wide, so the space is 8192 locations. The three chip-select straps let up to eight such devices sit on one bus and form a contiguous space of 64K bytes. A read stays inside its own device: the pointer wraps from 8191 to 0. To keep elaboration light, the storage behind the pointer is a parameter (`MEM_AW`, default 10 bits, so 1024 bytes). The low `MEM_AW` pointer bits index it, and higher pointer values alias onto it.

States of the byte sequencer:
- `ST_IDLE`: ignore the bus.
- `ST_CTRL`: shift in the control byte.
- `ST_CTRL_ACK`: drive the ninth-clock acknowledge.
- `ST_AHI` / `ST_AHI_ACK`: high address byte and its acknowledge.
- `ST_ALO` / `ST_ALO_ACK`: low address byte and its acknowledge.
- `ST_WDATA` / `ST_WDAT_ACK`: data byte and its acknowledge.
- `ST_RDATA`: shift a byte out.
- `ST_RD_ACK`: the master's acknowledge slot.

Transitions:
- Any state goes to `ST_IDLE` on a stop and to `ST_CTRL` on a start.
- `ST_CTRL` goes to `ST_CTRL_ACK` on the eighth SCL fall when the control byte matches, and to `ST_IDLE` when it does not.
- `ST_CTRL_ACK` goes to `ST_RDATA` for a read and to `ST_AHI` for a write.
- Each receive state goes to its own acknowledge state on the eighth fall.
- `ST_AHI_ACK` goes to `ST_ALO`. `ST_ALO_ACK` and `ST_WDAT_ACK` go to `ST_WDATA`.
- `ST_RDATA` goes to `ST_RD_ACK` after the eighth bit.
- `ST_RD_ACK` goes to `ST_RDATA` on a master acknowledge and to `ST_IDLE` on a not-acknowledge.

Top module: `i2c_eep_slave`

## Requirements
- R1: After reset, `sda_oe` is low and the address pointer is 0. A current-address read issued right after reset returns location 0, and reset leaves the stored bytes unchanged.
- R2: A stop (SDA rising while SCL is high) releases SDA and returns the block to idle at any point. A word address cut short by a stop leaves the pointer unchanged. A start (SDA falling while SCL is high) always begins a new control byte.
- R3: The block acknowledges a control byte only when bits 7:4 are 4'b1010 and bits 3:1 equal `cs_strap`. It drives SDA low for the whole ninth clock.
- R4: A control byte with a different device code or different chip-select bits gets no acknowledge. The block then leaves SDA untouched for the rest of the transfer and stores nothing.
- R5: In a write (control bit 0 = 0), the block acknowledges the high address byte, the low address byte and the data byte. It stores the data byte at the loaded address.
- R6: The top three bits of the high address byte are discarded. Only 13 address bits are kept.
- R7: In a read (control bit 0 = 1), the block shifts out the byte at the pointer, most significant bit first. The pointer then advances by one.
- R8: In a read, a master acknowledge makes the block send the next location. A master not-acknowledge makes it release SDA and go idle.
- R9: The pointer wraps from 8191 to 0, so a read never leaves the device.
- R10: Each stored byte advances the pointer, so a current-address read that follows a write returns the next location.
- R11: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the bus lines are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_strap | input | 3 | Chip-select strap that the control byte bits 3:1 must equal |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | High pulls SDA low (acknowledge or a zero read bit) |

## Verification
The bench addresses the device with a wrong device code and with wrong chip-select bits, then sends a full write after each. A block that decoded too loosely would acknowledge these bytes or overwrite the stored value. It writes to 8191 and reads on, so a pointer that ran past the device would return the wrong byte instead of location 0. It sends a high address byte with its top bits set, which catches a block that keeps those bits. It also stops a transfer in the middle of the address phase, which catches a sequencer that loads a partial address or stays out of step with the bytes. Sequential reads with an acknowledge followed by a not-acknowledge show whether the pointer advances and whether the bus is released. A monitor checks that the SDA enable never moves while SCL is high.

// File: rtl/i2c_eep_pkg.sv
package i2c_eep_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDATA,
        ST_WDAT_ACK,
        ST_RDATA,
        ST_RD_ACK
    } slv_state_e;

    // Fixed upper nibble of the control byte
    localparam logic [3:0] DEV_CODE = 4'b1010;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [1:0] raw;
    logic [1:0] cur;
    logic [1:0] prv;

    assign raw = {sda_i, scl_i};

    // index 0 = SCL, index 1 = SDA; both idle high
    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES:0] pipe;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[STAGES-1:0], raw[g]};
        end
        assign cur[g] = pipe[STAGES-1];
        assign prv[g] = pipe[STAGES];
    end

    assign sda_s     = cur[1];
    assign scl_rise  =  cur[0] & ~prv[0];
    assign scl_fall  = ~cur[0] &  prv[0];
    assign start_det =  cur[0] &  prv[0] & ~cur[1] &  prv[1];
    assign stop_det  =  cur[0] &  prv[0] &  cur[1] & ~prv[1];

endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int DATA_W = 8,
    parameter int AW     = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import i2c_eep_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int MEM_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_s,
    input  logic [2:0]        cs_strap,
    input  logic [7:0]        mem_rdata,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_waddr,
    output logic [7:0]        mem_wdata,
    output logic [ADDR_W-1:0] ptr,
    output logic              sda_oe,
    output slv_state_e        state,
    output logic [7:0]        rx_byte
);

    localparam int AHI_W = ADDR_W - 8;

    slv_state_e       nxt;
    logic [3:0]       bcnt;
    logic [7:0]       tx_byte;
    logic [AHI_W-1:0] addr_hi;
    logic             mst_ack;
    logic             ctrl_hit;
    logic             byte_done;

    assign ctrl_hit  = (rx_byte[7:4] == DEV_CODE) && (rx_byte[3:1] == cs_strap);
    assign byte_done = (bcnt == 4'd8);

    // next-state logic
    always_comb begin
        nxt = state;
        if (stop_det)       nxt = ST_IDLE;
        else if (start_det) nxt = ST_CTRL;
        else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_CTRL:     if (scl_fall && byte_done) nxt = ctrl_hit ? ST_CTRL_ACK : ST_IDLE;
                ST_CTRL_ACK: if (scl_fall) nxt = rx_byte[0] ? ST_RDATA : ST_AHI;
                ST_AHI:      if (scl_fall && byte_done) nxt = ST_AHI_ACK;
                ST_AHI_ACK:  if (scl_fall) nxt = ST_ALO;
                ST_ALO:      if (scl_fall && byte_done) nxt = ST_ALO_ACK;
                ST_ALO_ACK:  if (scl_fall) nxt = ST_WDATA;
                ST_WDATA:    if (scl_fall && byte_done) nxt = ST_WDAT_ACK;
                ST_WDAT_ACK: if (scl_fall) nxt = ST_WDATA;
                ST_RDATA:    if (scl_fall && bcnt == 4'd7) nxt = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) nxt = mst_ack ? ST_RDATA : ST_IDLE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt      <= '0;
            rx_byte   <= '0;
            tx_byte   <= '0;
            addr_hi   <= '0;
            ptr       <= '0;
            mst_ack   <= 1'b0;
            sda_oe    <= 1'b0;
            mem_we    <= 1'b0;
            mem_waddr <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= 1'b0;
            if (stop_det || start_det) begin
                bcnt   <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_CTRL, ST_AHI, ST_ALO, ST_WDATA: begin
                        if (scl_rise && !byte_done) begin
                            rx_byte <= {rx_byte[6:0], sda_s};
                            bcnt    <= bcnt + 4'd1;
                        end
                        if (scl_fall && byte_done) begin
                            bcnt <= '0;
                            if (state != ST_CTRL || ctrl_hit) sda_oe <= 1'b1;
                            if (state == ST_AHI) addr_hi <= rx_byte[AHI_W-1:0];
                            if (state == ST_ALO) ptr <= {addr_hi, rx_byte};
                            if (state == ST_WDATA) begin
                                mem_we    <= 1'b1;
                                mem_waddr <= ptr[MEM_AW-1:0];
                                mem_wdata <= rx_byte;
                                ptr       <= ptr + ADDR_W'(1);
                            end
                        end
                    end
                    ST_CTRL_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK: begin
                        if (scl_fall) begin
                            if (state == ST_CTRL_ACK && rx_byte[0]) begin
                                tx_byte <= mem_rdata;
                                sda_oe  <= ~mem_rdata[7];
                                ptr     <= ptr + ADDR_W'(1);
                                bcnt    <= '0;
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            if (bcnt == 4'd7) begin
                                sda_oe <= 1'b0;
                            end else begin
                                bcnt    <= bcnt + 4'd1;
                                tx_byte <= {tx_byte[6:0], 1'b0};
                                sda_oe  <= ~tx_byte[6];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) mst_ack <= ~sda_s;
                        if (scl_fall && mst_ack) begin
                            tx_byte <= mem_rdata;
                            sda_oe  <= ~mem_rdata[7];
                            ptr     <= ptr + ADDR_W'(1);
                            bcnt    <= '0;
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_eep_slave.sv
module i2c_eep_slave
    import i2c_eep_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int MEM_AW    = 10,
    parameter int SYNC_STGS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] cs_strap,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe
);

    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              mem_we;
    logic [MEM_AW-1:0] mem_waddr;
    logic [7:0]        mem_wdata;
    logic [7:0]        mem_rdata;
    logic [ADDR_W-1:0] ptr_w;
    slv_state_e        fsm_state;
    logic [7:0]        rx_byte_w;

    i2c_line_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_slave_fsm #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_s     (sda_s),
        .cs_strap  (cs_strap),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .ptr       (ptr_w),
        .sda_oe    (sda_oe),
        .state     (fsm_state),
        .rx_byte   (rx_byte_w)
    );

    eep_array #(.DATA_W(8), .AW(MEM_AW)) u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (ptr_w[MEM_AW-1:0]),
        .rdata (mem_rdata)
    );

endmodule

// File: rtl/i2c_eep_slave_chk.sv
module i2c_eep_slave_chk
    import i2c_eep_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic              stop_det,
    input logic [2:0]        cs_strap,
    input slv_state_e        state,
    input logic [ADDR_W-1:0] ptr,
    input logic [7:0]        rx_byte
);

    p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_i);

    p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe && state == ST_IDLE));

    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    p_ctrl_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CTRL_ACK) |-> (rx_byte[7:4] == 4'b1010 && rx_byte[3:1] == cs_strap));

    p_read_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDATA && $past(state) != ST_RDATA) |-> (ptr == $past(ptr) + ADDR_W'(1)));

endmodule

bind i2c_eep_slave i2c_eep_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .stop_det (stop_det),
    .cs_strap (cs_strap),
    .state    (fsm_state),
    .ptr      (ptr_w),
    .rx_byte  (rx_byte_w)
);

// File: tb/test_i2c_eep_slave.sv
module test_i2c_eep_slave;

    localparam int         Q     = 10;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;

    int n_checks = 0;
    int n_fail = 0;
    int hi_changes = 0;
    bit oe_seen = 1'b0;
    bit timed_out = 1'b0;
    logic prev_oe = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_eep_slave i_i2c_eep_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_strap (STRAP),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe)
    );

    // R11 monitor: enable changes seen while SCL is high
    always @(posedge clk) begin
        #1;
        if (sda_oe !== prev_oe && scl) hi_changes++;
        prev_oe = sda_oe;
        if (sda_oe) oe_seen = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        hq();
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; hq();
        scl = 1'b1;   hq();
        sda_m = 1'b0; hq();
        scl = 1'b0;   hq();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; hq();
        scl = 1'b1;   hq();
        sda_m = 1'b1; hq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hq();
            scl = 1'b1; hq(); hq();
            scl = 1'b0;
        end
        sda_m = 1'b1; hq();
        scl = 1'b1; hq();
        ack = ~sda_line;
        hq();
        scl = 1'b0;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            hq();
            scl = 1'b1; hq();
            b[i] = sda_line;
            hq();
            scl = 1'b0;
        end
        hq();
        sda_m = give_ack ? 1'b0 : 1'b1; hq();
        scl = 1'b1; hq(); hq();
        scl = 1'b0;
        repeat (3) @(negedge clk);
        sda_m = 1'b1;
    endtask

    // start, control write, two address bytes; no stop
    task automatic point(input logic [15:0] a, input string req);
        bit ack;
        i2c_start();
        send_byte({4'b1010, STRAP, 1'b0}, ack); chk(ack, req, ack, 1);
        send_byte(a[15:8], ack);                chk(ack, req, ack, 1);
        send_byte(a[7:0], ack);                 chk(ack, req, ack, 1);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input string req);
        bit ack;
        point(a, req);
        send_byte(d, ack); chk(ack, req, ack, 1);
        i2c_stop();
    endtask

    task automatic rd_cur(output logic [7:0] d);
        bit ack;
        i2c_start();
        send_byte({4'b1010, STRAP, 1'b1}, ack);
        chk(ack, "R3 read control ack", ack, 1);
        recv_byte(1'b0, d);
        i2c_stop();
    endtask

    task automatic t_reset();
        chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
        wr(16'h0000, 8'h5A, "R5 write loc0");
        do_reset();
        begin
            logic [7:0] d;
            rd_cur(d);
            chk(d == 8'h5A, "R1 pointer zero after reset", d, 8'h5A);
        end
    endtask

    task automatic t_write_basic();
        wr(16'h0123, 8'hA5, "R5 write ack");
    endtask

    task automatic t_random_read();
        logic [7:0] d;
        bit ack;
        point(16'h0123, "R5 address ack");
        i2c_start();
        send_byte({4'b1010, STRAP, 1'b1}, ack);
        chk(ack, "R3 repeated start control ack", ack, 1);
        recv_byte(1'b0, d);
        chk(d == 8'hA5, "R7 random read", d, 8'hA5);
        hq();
        chk(sda_oe == 1'b0, "R8 released after nack", sda_oe, 0);
        i2c_stop();
    endtask

    task automatic t_hi_ignored();
        logic [7:0] d;
        bit ack;
        wr(16'hE123, 8'h3C, "R6 write with high bits");
        point(16'h0123, "R6 address");
        i2c_start();
        send_byte({4'b1010, STRAP, 1'b1}, ack);
        recv_byte(1'b0, d);
        i2c_stop();
        chk(d == 8'h3C, "R6 top address bits discarded", d, 8'h3C);
    endtask

    task automatic t_mismatch();
        logic [7:0] d;
        bit ack;
        i2c_start();
        send_byte({4'b1010, 3'b001, 1'b0}, ack);
        chk(!ack, "R4 wrong chip select ack", ack, 0);
        oe_seen = 1'b0;
        send_byte(8'h01, ack);
        send_byte(8'h23, ack);
        send_byte(8'hFF, ack);
        chk(!oe_seen, "R4 silent after mismatch", oe_seen, 0);
        i2c_stop();
        i2c_start();
        send_byte({4'b1011, STRAP, 1'b0}, ack);
        chk(!ack, "R4 wrong device code ack", ack, 0);
        oe_seen = 1'b0;
        send_byte(8'h01, ack);
        send_byte(8'h23, ack);
        send_byte(8'hEE, ack);
        chk(!oe_seen, "R4 silent after bad code", oe_seen, 0);
        i2c_stop();
        point(16'h0123, "R4 address");
        i2c_start();
        send_byte({4'b1010, STRAP, 1'b1}, ack);
        recv_byte(1'b0, d);
        i2c_stop();
        chk(d == 8'h3C, "R4 memory untouched", d, 8'h3C);
    endtask

    task automatic t_write_incr();
        logic [7:0] d;
        wr(16'h0041, 8'h22, "R5 write 41");
        wr(16'h0040, 8'h11, "R5 write 40");
        rd_cur(d);
        chk(d == 8'h22, "R10 current read after write", d, 8'h22);
    endtask

    task automatic t_seq_read();
        logic [7:0] d;
        bit ack;
        point(16'h0040, "R7 address");
        i2c_start();
        send_byte({4'b1010, STRAP, 1'b1}, ack);
        recv_byte(1'b1, d);
        chk(d == 8'h11, "R7 first sequential byte", d, 8'h11);
        recv_byte(1'b1, d);
        chk(d == 8'h22, "R8 byte after master ack", d, 8'h22);
        recv_byte(1'b0, d);
        hq();
        chk(sda_oe == 1'b0, "R8 release after nack", sda_oe, 0);
        i2c_stop();
    endtask

    task automatic t_stop_abort();
        logic [7:0] d;
        bit ack;
        point(16'h0040, "R2 address");
        i2c_stop();
        i2c_start();
        send_byte({4'b1010, STRAP, 1'b0}, ack);
        send_byte(8'h01, ack);
        i2c_stop();
        chk(sda_oe == 1'b0, "R2 released after stop", sda_oe, 0);
        rd_cur(d);
        chk(d == 8'h11, "R2 partial address ignored", d, 8'h11);
    endtask

    task automatic t_wrap();
        logic [7:0] d;
        bit ack;
        wr(16'h0000, 8'h99, "R9 write 0");
        wr(16'h1FFF, 8'h77, "R9 write 1FFF");
        rd_cur(d);
        chk(d == 8'h99, "R9 pointer wrap after write", d, 8'h99);
        point(16'h1FFF, "R9 address");
        i2c_start();
        send_byte({4'b1010, STRAP, 1'b1}, ack);
        recv_byte(1'b1, d);
        chk(d == 8'h77, "R9 read top location", d, 8'h77);
        recv_byte(1'b0, d);
        chk(d == 8'h99, "R9 read wraps to 0", d, 8'h99);
        i2c_stop();
    endtask

    task automatic run_all();
        do_reset();
        t_reset();
        t_write_basic();
        t_random_read();
        t_hi_ignored();
        t_mismatch();
        t_write_incr();
        t_seq_read();
        t_stop_abort();
        t_wrap();
        chk(hi_changes == 0, "R11 sda_oe stable while SCL high", hi_changes, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        if (timed_out) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule